// File: doc/BRIEF.md
# E1 Receive Alarm Change-of-State Register

This block watches three receive-side conditions of an E1 framer and records every change in each of them. The conditions are loss of the recovered receive clock, the distant multiframe alarm carried in timeslot 16, and a link-identification hit reported by an external pattern checker. For each condition the block keeps two sticky bits. One records that the condition became true and the other records that it went away. A host can therefore see short alarms that have already cleared by the time it reads the register.

The receive line clock is brought into the system clock domain and timed with a counter. The timeslot-16 byte of frame 0 is checked once per multiframe. The host reads the 8-bit status and clears bits by writing ones. A host-writable 8-bit mask selects which latched bits drive the interrupt line.

Top module: `e1_rx_alarm_status`

## Requirements
- R1: After a synchronous active-low reset, `status`, `irq_mask` and `irq` are all 0.
- R2: Status bit positions are as follows. Bit 0 is distant alarm set and bit 4 is distant alarm gone. Bit 1 is link-ID set and bit 5 is link-ID gone. Bit 3 is clock loss set and bit 7 is clock loss gone. Bits 2 and 6 always read 0.
- R3: Clock loss becomes true when `rx_line_clk` makes no transition for more than 8*SYS_PER_BIT system clocks, and this sets bit 3. A gap of exactly 8*SYS_PER_BIT clocks does not set it.
- R4: Clock loss ends on the next transition of `rx_line_clk`, and this sets bit 7.
- R5: The distant alarm becomes true when `ts16_byte[2]` is 1 on the frame-0 byte (`ts16_stb` and `ts16_frame0` both high) of two consecutive multiframes, and this sets bit 0. Bytes with `ts16_frame0` low are ignored. A single 1, or two 1s with a 0 between them, does not set bit 0. `ts16_byte[2]` is the sixth bit when the bits are counted from 1 at the MSB.
- R6: The distant alarm ends when `ts16_byte[2]` is 0 on a single frame-0 byte, and this sets bit 4.
- R7: A rising edge of `link_id_hit` sets bit 1, and a falling edge sets bit 5.
- R8: When `clr_we` is high, each 1 in `clr_data` clears the matching status bit, and each 0 leaves it unchanged.
- R9: If a bit is cleared and set in the same cycle, it ends up set.
- R10: `irq` is high exactly when some bit is 1 in both `status` and `irq_mask`. `irq_mask` loads `mask_data` when `mask_we` is high.
- R11: A latched bit stays set after its condition changes again, until the host clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line_clk | input | 1 | Recovered receive clock, asynchronous |
| ts16_stb | input | 1 | Timeslot-16 byte valid |
| ts16_frame0 | input | 1 | Current byte belongs to frame 0 |
| ts16_byte | input | 8 | Received timeslot-16 byte |
| link_id_hit | input | 1 | Link-ID condition from the pattern checker |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_data | input | 8 | Bits to clear |
| mask_we | input | 1 | Mask write strobe |
| mask_data | input | 8 | New interrupt mask |
| status | output | 8 | Latched change-of-state register |
| irq_mask | output | 8 | Current interrupt mask |
| irq | output | 1 | Interrupt, high when any unmasked bit is set |

## Verification
A wrong edge register or a stuck history flag shows up at the ports within one or two clocks after the stimulus. It appears as a missing or extra bit in `status`. A wrong bit is also visible on `irq` once its mask bit is set.

The clock-loss counter is swept over gap lengths on both sides of the limit. An off-by-one in the counter therefore changes the observed bit 3 and bit 7 at the exact boundary gap. The distant-alarm history is probed with isolated, alternating and consecutive frame-0 flags, and with bytes that are not frame 0.

// File: rtl/e1_alarm_pkg.sv
// Shared constants for the E1 receive alarm status block.
// Assumes three monitored conditions packed into an 8-bit register.
package e1_alarm_pkg;
    localparam int NCOND   = 3;
    localparam int STAT_W  = 8;
    localparam int DMA_IDX = 2;                // frame-0 TS16 bit that carries the distant alarm
    localparam logic [STAT_W-1:0] USED_MASK = 8'hBB;

    // condition index: 0 distant alarm, 1 link-ID, 2 clock loss
    function automatic int det_pos(input int i);
        case (i)
            0:       return 0;
            1:       return 1;
            default: return 3;
        endcase
    endfunction

    function automatic int clr_pos(input int i);
        case (i)
            0:       return 4;
            1:       return 5;
            default: return 7;
        endcase
    endfunction
endpackage

// File: rtl/e1_rxclk_watch.sv
// Receive clock loss monitor.
// Synchronizes the line clock with two flops, detects every transition and
// counts system clocks since the last one. Loss is high while the count sits
// at the channel-time limit. Assumes SYS_PER_BIT system clocks per line bit.
module e1_rxclk_watch #(
    parameter int SYS_PER_BIT   = 16,
    parameter int BITS_PER_CHAN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line_clk,
    output logic loss
);
    localparam int LIMIT = SYS_PER_BIT * BITS_PER_CHAN;
    localparam int CW    = $clog2(LIMIT + 1);

    logic [2:0]    sync_q;
    logic          edge_seen;
    logic [CW-1:0] cnt_q;

    // two-flop synchronizer plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], rx_line_clk};
    end

    assign edge_seen = sync_q[2] ^ sync_q[1];

    // count idle system clocks, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (edge_seen)               cnt_q <= '0;
        else if (cnt_q != CW'(LIMIT))     cnt_q <= cnt_q + 1'b1;
    end

    assign loss = (cnt_q == CW'(LIMIT));

    p_edge_ends_loss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> !loss);
    p_loss_needs_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loss) |-> $past(!edge_seen));
endmodule

// File: rtl/e1_dist_mf_alarm.sv
// Distant multiframe alarm detector.
// Samples the alarm bit of each frame-0 timeslot-16 byte. The alarm rises when
// two consecutive samples are 1 and falls on any 0 sample. Assumes one frame-0
// byte per multiframe.
module e1_dist_mf_alarm
    import e1_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ts16_stb,
    input  logic       ts16_frame0,
    input  logic [7:0] ts16_byte,
    output logic       alarm
);
    logic sample, flag, seen_q;

    assign sample = ts16_stb & ts16_frame0;
    assign flag   = ts16_byte[DMA_IDX];

    // keep last frame-0 flag and update the alarm once per multiframe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            alarm  <= 1'b0;
        end else if (sample) begin
            seen_q <= flag;
            alarm  <= flag & seen_q;
        end
    end

    p_zero_ends_alarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !flag) |=> !alarm);
    p_alarm_needs_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> $past(seen_q && sample && flag));
endmodule

// File: rtl/e1_stat_latch.sv
// Change-of-state latch.
// For each live condition it sets a "became true" bit on a rising edge and a
// "went away" bit on a falling edge. Host write-one clears bits, and a set in
// the same cycle wins. Unused positions are forced to zero.
module e1_stat_latch
    import e1_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCOND-1:0]  cond,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_data,
    output logic [STAT_W-1:0] status
);
    logic [NCOND-1:0]  prev_q;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;

    // remember conditions from the previous clock
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cond;
    end

    // map each edge to its register bit
    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NCOND; i++) begin
            set_vec[det_pos(i)] = cond[i] & ~prev_q[i];
            set_vec[clr_pos(i)] = ~cond[i] & prev_q[i];
        end
    end

    assign clr_vec = clr_we ? clr_data : '0;

    // sticky register: clear first, then set, so the set wins
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= ((status & ~clr_vec) | set_vec) & USED_MASK;
    end

    p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] == 1'b0) && (status[6] == 1'b0));
    p_rise_latches_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cond[1] && !prev_q[1]) |=> status[1]);
    p_fall_latches_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cond[1] && prev_q[1]) |=> status[5]);
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> (($past(status) & ~status) == '0));
    p_clear_works_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((status & $past(clr_data) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/e1_rx_alarm_status.sv
// E1 receive alarm change-of-state register, top level.
// Combines the clock-loss monitor, the distant multiframe alarm detector and
// the external link-ID condition into one sticky status register. It also
// holds the interrupt mask and drives the interrupt. The line clock is
// asynchronous, and all other inputs are synchronous to clk.
module e1_rx_alarm_status
    import e1_alarm_pkg::*;
#(
    parameter int SYS_PER_BIT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_line_clk,
    input  logic        ts16_stb,
    input  logic        ts16_frame0,
    input  logic [7:0]  ts16_byte,
    input  logic        link_id_hit,
    input  logic        clr_we,
    input  logic [7:0]  clr_data,
    input  logic        mask_we,
    input  logic [7:0]  mask_data,
    output logic [7:0]  status,
    output logic [7:0]  irq_mask,
    output logic        irq
);
    logic loss, dma_alarm;
    logic [NCOND-1:0] cond;

    e1_rxclk_watch #(.SYS_PER_BIT(SYS_PER_BIT), .BITS_PER_CHAN(8)) u_watch (
        .clk(clk), .rst_n(rst_n), .rx_line_clk(rx_line_clk), .loss(loss)
    );

    e1_dist_mf_alarm u_dma (
        .clk(clk), .rst_n(rst_n), .ts16_stb(ts16_stb), .ts16_frame0(ts16_frame0),
        .ts16_byte(ts16_byte), .alarm(dma_alarm)
    );

    assign cond = {loss, link_id_hit, dma_alarm};

    e1_stat_latch u_latch (
        .clk(clk), .rst_n(rst_n), .cond(cond), .clr_we(clr_we),
        .clr_data(clr_data), .status(status)
    );

    // host-writable interrupt mask
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_mask <= '0;
        else if (mask_we) irq_mask <= mask_data;
    end

    assign irq = |(status & irq_mask);

    p_irq_quiet_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !irq);
    p_irq_quiet_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == '0) |-> !irq);
endmodule

// File: tb/sim_e1_rx_alarm_status.sv
module sim_e1_rx_alarm_status;
    localparam int SPB   = 2;
    localparam int LIMIT = 8 * SPB;

    logic clk = 1'b0, rst_n = 1'b0, rx_line_clk = 1'b0;
    logic ts16_stb = 1'b0, ts16_frame0 = 1'b0, link_id_hit = 1'b0;
    logic [7:0] ts16_byte = '0;
    logic clr_we = 1'b0, mask_we = 1'b0;
    logic [7:0] clr_data = '0, mask_data = '0;
    logic [7:0] status, irq_mask;
    logic irq;

    int total = 0, fails = 0, half = 4;
    bit done = 0;

    e1_rx_alarm_status #(.SYS_PER_BIT(SPB)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_line_clk(rx_line_clk), .ts16_stb(ts16_stb),
        .ts16_frame0(ts16_frame0), .ts16_byte(ts16_byte), .link_id_hit(link_id_hit),
        .clr_we(clr_we), .clr_data(clr_data), .mask_we(mask_we), .mask_data(mask_data),
        .status(status), .irq_mask(irq_mask), .irq(irq)
    );

    always #2 clk = ~clk;

    // line clock generator: toggles every 'half' system clocks
    initial forever begin
        repeat (half) @(negedge clk);
        rx_line_clk = ~rx_line_clk;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_write(input logic [7:0] d);
        @(negedge clk); clr_we = 1'b1; clr_data = d;
        @(negedge clk); clr_we = 1'b0; clr_data = '0;
    endtask

    task automatic mask_write(input logic [7:0] d);
        @(negedge clk); mask_we = 1'b1; mask_data = d;
        @(negedge clk); mask_we = 1'b0;
    endtask

    task automatic mf_byte(input logic f0, input logic bit6);
        @(negedge clk); ts16_stb = 1'b1; ts16_frame0 = f0; ts16_byte = bit6 ? 8'h04 : 8'hFB;
        @(negedge clk); ts16_stb = 1'b0; ts16_frame0 = 1'b0; ts16_byte = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        check("R1 status", status, 8'h00);
        check("R1 mask", irq_mask, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);

        // R3/R4 sweep of the idle gap around the channel-time limit
        for (int g = LIMIT - 4; g <= LIMIT + 4; g++) begin
            half = 4;
            wait_n(30);
            clr_write(8'hFF);
            half = g;
            wait_n(3 * g + 10);
            half = 4;
            wait_n(40);
            check(g > LIMIT ? "R3 R4 gap above limit" : "R3 gap within limit",
                  status, (g > LIMIT) ? 8'h88 : 8'h00);
        end

        // R10 one mask bit at a time against status 0x88
        for (int k = 0; k < 8; k++) begin
            mask_write(8'h01 << k);
            check("R10 irq per mask bit", {7'b0, irq}, {7'b0, (k == 3 || k == 7)});
        end
        mask_write(8'h00);
        check("R10 irq masked off", {7'b0, irq}, 8'h00);

        // R8 write-one-to-clear, zeros leave bits alone
        clr_write(8'h08);
        check("R8 clear bit3", status, 8'h80);
        clr_write(8'h00);
        check("R8 zero write no effect", status, 8'h80);
        clr_write(8'h80);
        check("R8 clear bit7", status, 8'h00);

        // R5 distant alarm: single, gapped, other frames, then consecutive
        mf_byte(1'b1, 1'b1); wait_n(3);
        check("R5 single flag", status, 8'h00);
        mf_byte(1'b1, 1'b0); mf_byte(1'b1, 1'b1); wait_n(3);
        check("R5 gapped flags", status, 8'h00);
        mf_byte(1'b0, 1'b1); mf_byte(1'b0, 1'b0); wait_n(3);
        check("R5 non-frame0 ignored", status, 8'h00);
        mf_byte(1'b1, 1'b1); wait_n(3);
        check("R5 two consecutive", status, 8'h01);
        mf_byte(1'b0, 1'b0); wait_n(3);
        check("R5 non-frame0 zero ignored", status, 8'h01);
        mf_byte(1'b1, 1'b0); wait_n(3);
        check("R6 R2 alarm gone bit4", status, 8'h11);
        clr_write(8'hFF);

        // R7 link-ID edges, R11 bits stay latched
        @(negedge clk); link_id_hit = 1'b1; wait_n(3);
        check("R7 link rise", status, 8'h02);
        @(negedge clk); link_id_hit = 1'b0; wait_n(3);
        check("R7 R11 link fall, rise kept", status, 8'h22);
        mask_write(8'h20);
        check("R10 irq on bit5", {7'b0, irq}, 8'h01);
        clr_write(8'hFF);
        check("R10 irq drops after clear", {7'b0, irq}, 8'h00);

        // R9 set wins over a clear in the same cycle
        @(negedge clk); link_id_hit = 1'b1; clr_we = 1'b1; clr_data = 8'hFF;
        @(negedge clk); clr_we = 1'b0; clr_data = 8'h00;
        check("R9 set beats clear", status, 8'h02);
        @(negedge clk); link_id_hit = 1'b0; clr_we = 1'b1; clr_data = 8'h22;
        @(negedge clk); clr_we = 1'b0; clr_data = 8'h00;
        check("R9 fall set beats clear", status, 8'h20);

        finish_run();
    end
endmodule